// File: doc/BRIEF.md
# Sequential Fraction Divider (Restoring, Non-Performing)

This block divides one positive binary fraction by another and returns the quotient one bit per clock, most significant bit first. Both operands are unsigned fixed-point values with the binary point just above the most significant bit, so an OPW-bit input `x` stands for `x / 2^OPW`. The caller must keep the dividend smaller than the divisor. That keeps the quotient below one and the running remainder below the divisor.

Each step doubles the running remainder and subtracts the divisor once. The sign of that difference gives the quotient bit. When the difference is negative, the doubled value is kept as the next remainder, so no add-back is needed. Every quotient bit costs exactly one subtraction and one sign test.

A caller pulses `start` while the block is idle. The operands are captured on that edge. The caller then waits for the one-cycle `done` pulse. After that pulse the quotient and the final remainder stay unchanged until the next accepted start.

Top module: `divr_frac_div`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `quotient` and `remainder` are 0.
- R2: `start` sampled high at a clock edge while `busy` is 0 captures `dividend` and `divisor` on that edge and raises `busy` on that same edge. Operand changes after that edge have no effect on the result.
- R3: For dividend N and divisor D with N < D, `quotient` equals floor(N * 2^QW / D), with quotient bit QW-1 the most significant.
- R4: `remainder` equals N * 2^QW - quotient * D, so it is always smaller than D.
- R5: `busy` stays high for exactly QW cycles after the start edge. `done` is high for exactly one cycle, which is the first cycle in which `busy` is low again.
- R6: `start` sampled high while `busy` is 1 is ignored. The running division keeps its operands, its result and its timing.
- R7: While `busy` is 0 and no start is accepted, `quotient` and `remainder` hold their values.
- R8: With QW = 8 and OPW = 8, dividing 5/8 (160) by 7/8 (224) gives leading quotient bits 1011 in `quotient[7:4]`. The full result is quotient 182 with remainder 192.
- R9: Throughout a division the running remainder stays below the divisor. Its doubled value therefore fits in OPW+1 bits, and a single subtraction decides each bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a division; honoured only when idle |
| dividend | input | OPW | Numerator fraction N, must be below the divisor |
| divisor | input | OPW | Denominator fraction D, nonzero |
| busy | output | 1 | High while quotient bits are being formed |
| done | output | 1 | One-cycle pulse when the result is ready |
| quotient | output | QW | Quotient fraction, MSB first |
| remainder | output | OPW | Final partial remainder, scaled by 2^-QW relative to the operands |

## Verification
With the start edge counted as edge 0, `busy` is high from edge 0 to edge QW. At edge QW, `done`, the full quotient and the final remainder all appear together. `done` drops again one edge later.

The bench drives inputs and samples outputs on falling edges. After releasing `start`, it counts falling edges until `done` is seen and requires that count to be exactly QW. It reads the results in that same half-cycle, then checks that `done` has dropped one edge later. It then checks that the results are unchanged several edges after that.

For the capture rule (R2) and the busy-start rule (R6), operands are altered, or a second start is pulsed, in cycles where the RTL must ignore them. The same latency and result checks are then repeated.

// File: rtl/divr_pkg.sv
package divr_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } divr_state_e;
endpackage

// File: rtl/divr_ctrl.sv
module divr_ctrl #(
  parameter int QW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic load,
  output logic step_en,
  output logic last_step,
  output logic done
);
  import divr_pkg::*;

  localparam int CW = $clog2(QW + 1);

  divr_state_e     state_q;
  logic [CW-1:0]   cnt_q;

  // A start is only honoured in the idle state (busy starts are dropped).
  assign load      = start && (state_q == ST_IDLE);
  assign step_en   = (state_q == ST_RUN);
  assign last_step = step_en && (cnt_q == CW'(1));
  assign busy      = step_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= last_step;
      if (load) begin
        state_q <= ST_RUN;
        cnt_q   <= CW'(QW);
      end else if (step_en) begin
        cnt_q <= cnt_q - CW'(1);
        if (last_step) state_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/divr_datapath.sv
module divr_datapath #(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step_en,
  input  logic [OPW-1:0] dividend,
  input  logic [OPW-1:0] divisor,
  output logic           q_bit,
  output logic           ovf_bit,
  output logic [OPW-1:0] part_rem,
  output logic [OPW-1:0] div_hold
);
  localparam int DW = OPW + 1;  // doubled remainder width
  localparam int TW = OPW + 2;  // trial width, MSB is the sign

  // Trial difference: doubled remainder minus divisor, one guard bit for sign.
  function automatic logic [TW-1:0] trial_of(input logic [DW-1:0] dbl,
                                             input logic [OPW-1:0] d);
    return {1'b0, dbl} - {2'b00, d};
  endfunction

  logic [DW-1:0] dbl_hold;
  logic [TW-1:0] trial;
  logic [DW-1:0] next_rem;

  // Doubled remainder is kept aside and chosen when the trial goes negative.
  assign dbl_hold = {part_rem, 1'b0};
  assign trial    = trial_of(dbl_hold, div_hold);
  assign q_bit    = ~trial[TW-1];
  assign next_rem = q_bit ? trial[DW-1:0] : dbl_hold;
  assign ovf_bit  = next_rem[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_rem <= '0;
      div_hold <= '0;
    end else if (load) begin
      part_rem <= dividend;
      div_hold <= divisor;
    end else if (step_en) begin
      part_rem <= next_rem[OPW-1:0];
    end
  end
endmodule

// File: rtl/divr_qreg.sv
module divr_qreg #(
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step_en,
  input  logic          q_bit,
  output logic [QW-1:0] quotient
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quotient <= '0;
    end else if (load) begin
      quotient <= '0;
    end else if (step_en) begin
      quotient <= {quotient[QW-2:0], q_bit};
    end
  end
endmodule

// File: rtl/divr_frac_div.sv
module divr_frac_div #(
  parameter int QW  = 8,
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] dividend,
  input  logic [OPW-1:0] divisor,
  output logic           busy,
  output logic           done,
  output logic [QW-1:0]  quotient,
  output logic [OPW-1:0] remainder
);
  // Internal events, named for the bound checker.
  logic           load;
  logic           step_en;
  logic           last_step;
  logic           q_bit;
  logic           ovf_bit;
  logic [OPW-1:0] part_rem;
  logic [OPW-1:0] div_hold;

  divr_ctrl #(.QW(QW)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .load      (load),
    .step_en   (step_en),
    .last_step (last_step),
    .done      (done)
  );

  divr_datapath #(.OPW(OPW)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step_en  (step_en),
    .dividend (dividend),
    .divisor  (divisor),
    .q_bit    (q_bit),
    .ovf_bit  (ovf_bit),
    .part_rem (part_rem),
    .div_hold (div_hold)
  );

  divr_qreg #(.QW(QW)) qreg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step_en  (step_en),
    .q_bit    (q_bit),
    .quotient (quotient)
  );

  assign remainder = part_rem;
endmodule

// File: rtl/divr_frac_div_chk.sv
module divr_frac_div_chk #(
  parameter int QW  = 8,
  parameter int OPW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           step_en,
  input logic           last_step,
  input logic           ovf_bit,
  input logic [QW-1:0]  quotient,
  input logic [OPW-1:0] remainder,
  input logic [OPW-1:0] part_rem,
  input logic [OPW-1:0] div_hold
);
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r5_busy_until_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> busy);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));

  a_r9_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (part_rem < div_hold));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> !ovf_bit);
endmodule

bind divr_frac_div divr_frac_div_chk #(.QW(QW), .OPW(OPW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .step_en   (step_en),
  .last_step (last_step),
  .ovf_bit   (ovf_bit),
  .quotient  (quotient),
  .remainder (remainder),
  .part_rem  (part_rem),
  .div_hold  (div_hold)
);

// File: tb/divr_frac_div_tb_top.sv
module divr_frac_div_tb_top;
  localparam int QW  = 8;
  localparam int OPW = 8;
  localparam int NV  = 8;

  // {dividend, divisor}, all with dividend < divisor
  localparam logic [15:0] VEC [NV] = '{
    {8'd160, 8'd224}, {8'd1,   8'd255}, {8'd0,  8'd200}, {8'd254, 8'd255},
    {8'd127, 8'd128}, {8'd100, 8'd101}, {8'd3,  8'd7},   {8'd85,  8'd170}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [OPW-1:0] dividend = '0;
  logic [OPW-1:0] divisor = '0;
  logic           busy, done;
  logic [QW-1:0]  quotient;
  logic [OPW-1:0] remainder;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  divr_frac_div #(.QW(QW), .OPW(OPW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one division; if poke_at > 0, a second start with other operands is
  // pulsed that many cycles into the run (must be ignored).
  task automatic run_div(input int n, input int d, input int poke_at, input string req);
    int k;
    longint exp_q, exp_r;
    exp_q = (longint'(n) << QW) / d;
    exp_r = (longint'(n) << QW) - exp_q * d;
    @(negedge clk);
    dividend = OPW'(n);
    divisor  = OPW'(d);
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    dividend = 8'hAA;   // R2: later changes must not matter
    divisor  = 8'h0F;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    k = 0;
    while (!done && k < 4 * QW) begin
      @(negedge clk);
      k++;
      if (poke_at > 0 && k == poke_at) begin
        dividend = 8'd1;
        divisor  = 8'd3;
        start    = 1'b1;
        @(negedge clk);
        k++;
        start = 1'b0;
      end
    end
    check(k == QW, {req, " R5 latency"}, k, QW);
    check(quotient == QW'(exp_q), {req, " R3 quotient"}, quotient, exp_q);
    check(remainder == OPW'(exp_r), {req, " R4 remainder"}, remainder, exp_r);
    check(remainder < d, {req, " R9 remainder below divisor"}, remainder, d);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, {req, " R5 done single cycle"}, done, 0);
    repeat (3) @(negedge clk);
    check(quotient == QW'(exp_q) && remainder == OPW'(exp_r),
          {req, " R7 outputs held"}, quotient, exp_q);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0, "R1 flags in reset", {busy, done}, 0);
    check(quotient == 0 && remainder == 0, "R1 outputs in reset", quotient, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && quotient == 0, "R1 idle after reset", busy, 0);

    for (int i = 0; i < NV; i++)
      run_div(int'(VEC[i][15:8]), int'(VEC[i][7:0]), 0, "R3 vector");

    // R8: 5/8 by 7/8
    run_div(160, 224, 0, "R8");
    check(quotient[7:4] == 4'b1011, "R8 leading bits", quotient[7:4], 4'b1011);
    check(quotient == 8'd182 && remainder == 8'd192, "R8 full result", quotient, 182);

    // R6: start while busy is ignored
    run_div(77, 200, 3, "R6");
    run_div(250, 251, 1, "R6");

    // R7 hold with operand inputs toggling while idle
    dividend = 8'd5;
    divisor  = 8'd9;
    repeat (4) @(negedge clk);
    check(quotient == QW'((250 * 256) / 251), "R7 hold with idle inputs", quotient, (250 * 256) / 251);

    // R1 reset mid-run
    @(negedge clk);
    dividend = 8'd10; divisor = 8'd20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(busy == 0 && done == 0 && quotient == 0 && remainder == 0,
          "R1 reset during run", quotient, 0);
    rst_n = 1'b1;
    run_div(10, 20, 0, "R1 after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule